// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets an on-chip host read and write a byte-wide asynchronous static RAM that has an 18-bit address. The host issues one request at a time. Each request carries an address, a write flag and write data, and is taken only while `req_ready` is high. The controller then drives the memory's select, write-enable and output-enable strobes and its address bus for a fixed number of clock cycles. At the end it raises `rsp_done` for one cycle, and on a read it presents the captured byte on `rsp_rdata`.

Each phase length is a whole number of clock cycles. It is computed at elaboration from the nanosecond limits of the chosen speed grade (70, 85 or 100 ns, picked by `SPEED_GRADE` = 0, 1 or 2) and from `CLK_PERIOD_NS`. Each value is the ceiling of the time divided by the period, and never less than one cycle.

The data bus is split into an output, an input and an output enable, so a pad ring or the bench can build the tri-state pin. The controller never drives the bus while the memory may still be driving it.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset, and whenever the controller is idle, `sram_cs1_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: Every phase count equals ceil(ns / `CLK_PERIOD_NS`), with a minimum of 1. The default (grade 0, 8 ns clock) gives a read phase of 9, a write pulse of 8, a write recovery of 1 and a bus release of 3 cycles.
- R3: An accepted read holds `sram_cs1_n` = 0, `sram_oe_n` = 0, `sram_we_n` = 1 and `sram_dq_oe` = 0, with the request address on `sram_addr`, for ceil(max(read cycle, address access, output-enable access) / period) cycles, starting at the edge that accepts the request.
- R4: Read data is sampled from `sram_dq_in` on the last clock of the read phase. It appears on `rsp_rdata` in the cycle `rsp_done` is high and holds until the next read ends.
- R5: An accepted write holds `sram_we_n` = 0, `sram_cs1_n` = 0, `sram_oe_n` = 1 and `sram_dq_oe` = 1, with the write data on `sram_dq_out`, for ceil(max(write pulse, select-to-end, address-to-end, data-to-end) / period) cycles. Then `sram_we_n` returns to 1 while select, address and data stay unchanged for max(1, ceil(write cycle / period) − pulse) cycles.
- R6: `rsp_done` is high for exactly one cycle per request. It is high in the cycle right after the last read-phase cycle or the last write-recovery cycle.
- R7: After a read, `req_ready` stays 0 for ceil(output release time / period) cycles, counted from the cycle in which `rsp_done` is high. During that time select and output enable are 1 and the bus is not driven.
- R8: `req_valid` is ignored while `req_ready` is 0. The strobes, the address and the memory contents are not disturbed, and no extra `rsp_done` appears.
- R9: `sram_dq_oe` and an active `sram_oe_n` = 0 are never high and low together, and `sram_dq_oe` rises no earlier than the output release time after `sram_oe_n` last rose.
- R10: `sram_cs2` is held at 1 at all times. Selection is done with `sram_cs1_n` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last read byte |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select, tied high |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_addr | output | 18 | Memory address bus |
| sram_dq_out | output | 8 | Data driven toward the memory |
| sram_dq_in | input | 8 | Data returned by the memory |
| sram_dq_oe | output | 1 | Enable for the data bus driver |

## Verification
All strobes change at the same edge as the state register, because they are registered from the next state. The edge that accepts a request therefore starts its first phase.

For a read, `rsp_done` and `rsp_rdata` are due after the 9th edge counted from the accepting one, and `req_ready` returns three edges later. For a write, `sram_we_n` rises after the 8th edge and `rsp_done` arrives after the 9th.

The bench samples on the falling clock edge and counts edges from acceptance. Each strobe is compared against its expected value at every such sample. The bench's memory model returns a poisoned byte until 70 ns after select, output enable and address last changed, so a read phase that is too short is caught.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int unsigned DEF_ADDR_W = 18;
    localparam int unsigned DEF_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WR,
        ST_REC
    } ctl_state_e;

    typedef struct packed {
        logic cs1_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    typedef struct packed {
        int unsigned rd_cycle;
        int unsigned addr_acc;
        int unsigned oe_acc;
        int unsigned we_pulse;
        int unsigned sel_to_end;
        int unsigned adr_to_end;
        int unsigned dat_to_end;
        int unsigned wr_cycle;
        int unsigned release_t;
    } grade_ns_t;

    function automatic grade_ns_t grade_table(input int unsigned grade);
        grade_ns_t g;
        case (grade)
            1:       g = '{85,  85,  45, 60, 70, 70, 35, 85,  25};
            2:       g = '{100, 100, 50, 70, 80, 80, 40, 100, 30};
            default: g = '{70,  70,  40, 50, 60, 60, 35, 70,  20};
        endcase
        return g;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic strobe_t strobes_for(input ctl_state_e s);
        strobe_t p;
        p = '{cs1_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        case (s)
            ST_RD: begin
                p.cs1_n = 1'b0;
                p.oe_n  = 1'b0;
            end
            ST_WR: begin
                p.cs1_n = 1'b0;
                p.we_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            ST_REC: begin
                p.cs1_n = 1'b0;
                p.dq_oe = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned RD_CYC  = 9,
    parameter int unsigned WP_CYC  = 8,
    parameter int unsigned REC_CYC = 1,
    parameter int unsigned HZ_CYC  = 3,
    parameter int unsigned CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output ctl_state_e       state_q,
    output ctl_state_e       state_d,
    output logic             accept,
    output logic             capture,
    output logic             done
);
    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LD  = CNT_W'(HZ_CYC - 1);

    logic done_d;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        done_d   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR;
                        tmr_val = WP_LD;
                    end else begin
                        state_d = ST_RD;
                        tmr_val = RD_LD;
                    end
                end
            end
            ST_RD: begin
                if (tmr_expired) begin
                    capture  = 1'b1;
                    done_d   = 1'b1;
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = HZ_LD;
                end
            end
            ST_TURN: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_WR: begin
                if (tmr_expired) begin
                    state_d  = ST_REC;
                    tmr_load = 1'b1;
                    tmr_val  = REC_LD;
                end
            end
            ST_REC: begin
                if (tmr_expired) begin
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= done_d;
        end
    end
endmodule

// File: rtl/sram_ctl_iob.sv
module sram_ctl_iob
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_state_e        state_d,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic              cs1_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rdata
);
    strobe_t strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= strobes_for(ST_IDLE);
            addr     <= '0;
            dq_out   <= '0;
            rdata    <= '0;
        end else begin
            strobe_q <= strobes_for(state_d);
            if (accept) begin
                addr   <= req_addr;
                dq_out <= req_wdata;
            end
            if (capture) rdata <= dq_in;
        end
    end

    assign cs1_n = strobe_q.cs1_n;
    assign we_n  = strobe_q.we_n;
    assign oe_n  = strobe_q.oe_n;
    assign dq_oe = strobe_q.dq_oe;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = DEF_ADDR_W,
    parameter int unsigned DATA_W        = DEF_DATA_W,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned SPEED_GRADE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sram_cs1_n,
    output logic              sram_cs2,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);
    localparam grade_ns_t TG = grade_table(SPEED_GRADE);

    localparam int unsigned RD_CYC =
        ns_to_cyc(umax(TG.rd_cycle, umax(TG.addr_acc, TG.oe_acc)), CLK_PERIOD_NS);
    localparam int unsigned WP_CYC =
        ns_to_cyc(umax(umax(TG.we_pulse, TG.sel_to_end),
                       umax(TG.adr_to_end, TG.dat_to_end)), CLK_PERIOD_NS);
    localparam int unsigned WC_CYC  = ns_to_cyc(TG.wr_cycle, CLK_PERIOD_NS);
    localparam int unsigned REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int unsigned HZ_CYC  = ns_to_cyc(TG.release_t, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WP_CYC), umax(REC_CYC, HZ_CYC));
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_e       state_q;
    ctl_state_e       state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctl_seq #(
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .REC_CYC(REC_CYC),
        .HZ_CYC (HZ_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .state_q    (state_q),
        .state_d    (state_d),
        .accept     (accept),
        .capture    (capture),
        .done       (rsp_done)
    );

    sram_ctl_iob #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_iob (
        .clk      (clk),
        .rst      (rst),
        .state_d  (state_d),
        .accept   (accept),
        .capture  (capture),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .dq_in    (sram_dq_in),
        .cs1_n    (sram_cs1_n),
        .we_n     (sram_we_n),
        .oe_n     (sram_oe_n),
        .dq_oe    (sram_dq_oe),
        .addr     (sram_addr),
        .dq_out   (sram_dq_out),
        .rdata    (rsp_rdata)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign sram_cs2  = 1'b1;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int unsigned ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              sram_cs1_n,
    input logic              sram_cs2,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_cs1_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    // R3
    read_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (sram_we_n && !sram_cs1_n && !sram_dq_oe));

    // R5
    write_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_oe_n && sram_dq_oe && !sram_cs1_n));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs1_n && $past(!sram_cs1_n)) |-> $stable(sram_addr));

    // R9
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !(sram_dq_oe && !sram_oe_n));

    // R10
    cs2_high_chk: assert property (@(posedge clk) disable iff (rst)
        sram_cs2);
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .sram_cs1_n(sram_cs1_n),
    .sram_cs2  (sram_cs2),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n),
    .sram_dq_oe(sram_dq_oe),
    .sram_addr (sram_addr)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
    localparam int P       = 8;
    localparam int RD_EXP  = (70 + P - 1) / P;
    localparam int WP_EXP  = (60 + P - 1) / P;
    localparam int WC_EXP  = (70 + P - 1) / P;
    localparam int REC_EXP = (WC_EXP > WP_EXP) ? WC_EXP - WP_EXP : 1;
    localparam int HZ_EXP  = (20 + P - 1) / P;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata;
    logic        sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [17:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = 8'hEE;

    int n_chk  = 0;
    int n_fail = 0;
    int n_viol = 0;

    logic [7:0] mem [bit [17:0]];
    time t_sel = 0, t_wf = 0, t_cf = 0, t_oer = 0;

    always #(P/2) clk = ~clk;

    sram_ctl dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
    );

    // memory model: data valid only 70 ns after select/enable/address settle
    always @(sram_cs1_n, sram_oe_n, sram_addr) t_sel = $time;
    always @(negedge sram_we_n) t_wf = $time;
    always @(negedge sram_cs1_n) t_cf = $time;
    always @(posedge sram_oe_n) t_oer = $time;
    always @(posedge sram_dq_oe) if ($time - t_oer < 20) n_viol++;
    always @(posedge sram_we_n) begin
        if (sram_cs1_n === 1'b0) begin
            if (($time - t_wf) < 50 || ($time - t_cf) < 60 || sram_dq_oe !== 1'b1) n_viol++;
            mem[sram_addr] = sram_dq_out;
        end
    end
    initial begin
        forever begin
            #1;
            if (sram_cs1_n === 1'b0 && sram_cs2 === 1'b1 && sram_oe_n === 1'b0 &&
                sram_we_n === 1'b1 && ($time - t_sel) >= 70)
                sram_dq_in = mem.exists(sram_addr) ? mem[sram_addr] : 8'h00;
            else
                sram_dq_in = 8'hEE;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        chk("R8 ready before write", req_ready, 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        for (int j = 1; j <= WP_EXP + REC_EXP + 2; j++) begin
            @(negedge clk);
            if (j == 1) req_valid = 1'b0;
            if (j <= WP_EXP + REC_EXP) begin
                chk("R5 we_n", sram_we_n, (j <= WP_EXP) ? 0 : 1);
                chk("R5 cs1_n", sram_cs1_n, 0);
                chk("R5 oe_n", sram_oe_n, 1);
                chk("R5 dq_oe", sram_dq_oe, 1);
                chk("R5 dq_out", sram_dq_out, d);
                chk("R5 addr", sram_addr, a);
            end else begin
                chk("R1 cs1_n idle after write", sram_cs1_n, 1);
                chk("R1 ready after write", req_ready, 1);
            end
            chk("R6 write done", rsp_done, (j == WP_EXP + REC_EXP + 1) ? 1 : 0);
            chk("R10 cs2", sram_cs2, 1);
        end
    endtask

    task automatic do_read(input logic [17:0] a, input logic [7:0] exp, input bit poke);
        @(negedge clk);
        chk("R8 ready before read", req_ready, 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        for (int j = 1; j <= RD_EXP + HZ_EXP + 1; j++) begin
            @(negedge clk);
            if (j == 1 || j == 4 || j == RD_EXP + 2) req_valid = 1'b0;
            if (j <= RD_EXP) begin
                chk("R3 oe_n", sram_oe_n, 0);
                chk("R3 we_n", sram_we_n, 1);
                chk("R3 cs1_n", sram_cs1_n, 0);
                chk("R3 dq_oe", sram_dq_oe, 0);
                chk("R3 R8 addr", sram_addr, a);
                chk("R6 no early done", rsp_done, 0);
                chk("R7 ready low", req_ready, 0);
            end else if (j == RD_EXP + 1) begin
                chk("R6 read done", rsp_done, 1);
                chk("R4 rdata", rsp_rdata, exp);
                chk("R7 ready low at done", req_ready, 0);
                chk("R7 oe_n released", sram_oe_n, 1);
            end else begin
                chk("R6 done one cycle", rsp_done, 0);
                chk("R4 rdata held", rsp_rdata, exp);
                chk("R7 ready release", req_ready, (j == RD_EXP + HZ_EXP + 1) ? 1 : 0);
                chk("R7 dq_oe off", sram_dq_oe, 0);
                chk("R7 cs1_n high", sram_cs1_n, 1);
            end
            if (poke && (j == 3 || j == RD_EXP + 1)) begin
                req_valid = 1'b1; req_write = 1'b1;
                req_addr = 18'h00777; req_wdata = 8'h99;
            end
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 cs1_n in reset", sram_cs1_n, 1);
        chk("R1 we_n in reset", sram_we_n, 1);
        chk("R1 oe_n in reset", sram_oe_n, 1);
        chk("R1 dq_oe in reset", sram_dq_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready", req_ready, 1);
        chk("R1 done", rsp_done, 0);
        chk("R10 cs2", sram_cs2, 1);
        chk("R2 phase counts", {RD_EXP[7:0], WP_EXP[7:0], REC_EXP[7:0], HZ_EXP[7:0]}, 32'h09080103);
    endtask

    task automatic t_basic;
        do_write(18'h00000, 8'hA5);
        do_read(18'h00000, 8'hA5, 0);
    endtask

    task automatic t_pattern;
        do_write(18'h3FFFF, 8'h5A);
        do_write(18'h12345, 8'h3C);
        do_write(18'h2AAAA, 8'hFF);
        do_write(18'h15555, 8'h00);
        do_read(18'h2AAAA, 8'hFF, 0);
        do_read(18'h3FFFF, 8'h5A, 0);
        do_write(18'h00777, 8'h11);
        do_read(18'h15555, 8'h00, 0);
        do_read(18'h12345, 8'h3C, 0);
    endtask

    task automatic t_busy;
        do_read(18'h3FFFF, 8'h5A, 1);
        do_read(18'h00777, 8'h11, 0);
        chk("R8 poked location untouched", mem[18'h00777], 8'h11);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_pattern();
        t_busy();
        chk("R5 R9 bus timing violations", n_viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * P);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule